// File: doc/BRIEF.md
# Password-guarded watchdog and interval timer

This block is a supervision timer for a small controller. Its configuration lives in one 16-bit register. Software writes that register as a single word. The high byte must carry a fixed key. The low byte carries the command: run or stop, which count source to use, watchdog or interval-timer behaviour, a four-way interval select, a counter restart and a one-time lock.

A write with the wrong key is treated as evidence of runaway code. It raises a one-cycle system reset request at once. In watchdog mode the same reset request fires when the count runs out before software restarts it. A latched pair of cause flags records which of the two events happened last.

In interval-timer mode a count expiry sets a sticky interrupt flag instead, and the count starts over. Once the lock bit has been written, the settings are frozen. After that, keyed writes may only restart the count, and any other write is a violation.

Top module: `wdt_keyguard`

## Requirements
- R1: A write is accepted only when wr_data[15:8] equals 0x5A. An accepted write on an unlocked block stores run enable from bit 0, source select from bit 1, interval-timer mode from bit 2, interval select from bits 5:4 and lock from bit 6.
- R2: A write whose upper byte differs from 0x5A raises sys_rst_req for exactly the next cycle. It sets cause_key, clears cause_timeout, restarts the count and leaves the stored settings unchanged.
- R3: rd_data reads 0x69 in bits 15:8. Bits 7:0 read {0, lock, interval select[1:0], 0, mode, source, enable}, so the reserved bits 7 and 3 read zero.
- R4: Bit 3 of an accepted write restarts the count from zero and clears irq_flag. The bit itself is not stored.
- R5: In watchdog mode the count expires after exactly 2^N counted ticks since the last restart. On expiry sys_rst_req pulses high for one cycle, cause_timeout is set and cause_key is cleared. The two cause flags are never both high.
- R6: Interval select 00, 01, 10 and 11 give N = 6, 9, 13 and 15.
- R7: With run enable at 0 the count holds, and no expiry occurs.
- R8: With source select 0 every clock cycle is a tick. With source select 1 only cycles with tick_aux high are ticks.
- R9: In interval-timer mode an expiry sets irq_flag, which stays high until a restart. The count wraps to zero and no reset request is raised.
- R10: After an accepted write with the lock bit set, the settings cannot change until rst_n. A keyed write with bit 3 set then only restarts the count. A keyed write with bit 3 clear is a violation, handled as in R2.
- R11: After rst_n the settings are 0x31 (running, clock-cycle source, watchdog mode, N = 15, unlocked), and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_aux | input | 1 | Count enable used when source select is 1 |
| wr_en | input | 1 | Write strobe for the control word, one cycle per write |
| wr_data | input | 16 | Control word: key in bits 15:8, command in bits 7:0 |
| rd_data | output | 16 | Read value of the control register |
| sys_rst_req | output | 1 | One-cycle system reset request |
| cause_timeout | output | 1 | Last reset request came from a count expiry |
| cause_key | output | 1 | Last reset request came from a key or lock violation |
| irq_flag | output | 1 | Sticky interval-timer expiry flag |

## Verification
The checker assumes that wr_en is a one-cycle strobe. It also assumes that nothing drives the block other than this write path and tick_aux. Its properties look only at the cycle after a write or a quiet cycle.

The stimulus therefore separates every write by at least one idle cycle. It changes tick_aux only at falling clock edges. It starts each timing measurement from a restart write, so the bench always knows the count exactly.

// File: rtl/wdt_keyguard.sv
`timescale 1ns/1ps
module wdt_keyguard #(
  parameter logic [7:0] KEY   = 8'h5A,
  parameter logic [7:0] RD_ID = 8'h69,
  parameter int SH0 = 6,
  parameter int SH1 = 9,
  parameter int SH2 = 13,
  parameter int SH3 = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_aux,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        sys_rst_req,
  output logic        cause_timeout,
  output logic        cause_key,
  output logic        irq_flag
);
  localparam int CNT_W = SH3;
  localparam logic [CNT_W-1:0] TC0 = CNT_W'((1 << SH0) - 1);
  localparam logic [CNT_W-1:0] TC1 = CNT_W'((1 << SH1) - 1);
  localparam logic [CNT_W-1:0] TC2 = CNT_W'((1 << SH2) - 1);
  localparam logic [CNT_W-1:0] TC3 = CNT_W'((1 << SH3) - 1);

  logic             run, src, itm, lock;
  logic [1:0]       isel;
  logic [CNT_W-1:0] cnt, last;
  logic             key_ok, viol, cfg_wr, clr, tick, hit;
  wire              unused_bit7 = wr_data[7];

  assign key_ok = wr_data[15:8] == KEY;
  assign viol   = wr_en && (!key_ok || (lock && !wr_data[3]));
  assign cfg_wr = wr_en && key_ok && !lock;
  assign clr    = wr_en && key_ok && wr_data[3];
  assign tick   = run && (src ? tick_aux : 1'b1);

  always_comb begin
    case (isel)
      2'd0:    last = TC0;
      2'd1:    last = TC1;
      2'd2:    last = TC2;
      default: last = TC3;
    endcase
  end

  assign hit = tick && (cnt >= last) && !clr && !viol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {lock, isel, itm, src, run} <= 6'b0_11_0_0_1;
    end else if (cfg_wr) begin
      run  <= wr_data[0];
      src  <= wr_data[1];
      itm  <= wr_data[2];
      isel <= wr_data[5:4];
      lock <= wr_data[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || viol)  cnt <= '0;
    else if (hit)          cnt <= '0;
    else if (tick)         cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst_req   <= 1'b0;
      cause_timeout <= 1'b0;
      cause_key     <= 1'b0;
      irq_flag      <= 1'b0;
    end else begin
      sys_rst_req <= viol || (hit && !itm);
      if (viol) begin
        cause_key     <= 1'b1;
        cause_timeout <= 1'b0;
      end else if (hit && !itm) begin
        cause_key     <= 1'b0;
        cause_timeout <= 1'b1;
      end
      if (clr)              irq_flag <= 1'b0;
      else if (hit && itm)  irq_flag <= 1'b1;
    end
  end

  assign rd_data = {RD_ID, 1'b0, lock, isel, 1'b0, itm, src, run};
endmodule

module wdt_keyguard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        sys_rst_req,
  input logic        cause_timeout,
  input logic        cause_key
);
  p_badkey_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[15:8] != 8'h5A |=> sys_rst_req && cause_key && $stable(rd_data[7:0]));
  p_cause_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cause_timeout, cause_key}));
  p_timeout_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req && !cause_key |-> cause_timeout);
  p_stopped_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] && !wr_en |=> !sys_rst_req);
  p_itm_no_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2] && !wr_en |=> !sys_rst_req);
  p_locked_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] |=> $stable(rd_data[7:0]));
endmodule

bind wdt_keyguard wdt_keyguard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .sys_rst_req(sys_rst_req), .cause_timeout(cause_timeout), .cause_key(cause_key)
);

// File: tb/test_wdt_keyguard.sv
`timescale 1ns/1ps
module test_wdt_keyguard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_aux = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        sys_rst_req, cause_timeout, cause_key, irq_flag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct { string req; logic [19:0] exp; } item_t;
  item_t exp_q[$];
  event  sample_ev;

  always #2.5 clk = ~clk;

  wdt_keyguard i_wdt_keyguard (
    .clk(clk), .rst_n(rst_n), .tick_aux(tick_aux), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sys_rst_req(sys_rst_req), .cause_timeout(cause_timeout),
    .cause_key(cause_key), .irq_flag(irq_flag)
  );

  function automatic logic [19:0] mk(logic [15:0] rd, logic r, logic t, logic k, logic i);
    return {rd, r, t, k, i};
  endfunction

  always begin
    @(sample_ev);
    while (exp_q.size() > 0) begin
      item_t it;
      logic [19:0] obs;
      it  = exp_q.pop_front();
      obs = {rd_data, sys_rst_req, cause_timeout, cause_key, irq_flag};
      checks++;
      if (obs !== it.exp) begin
        failures++;
        $display("FAIL %s actual rd=%h rst=%b to=%b key=%b irq=%b expected rd=%h rst=%b to=%b key=%b irq=%b",
                 it.req, obs[19:4], obs[3], obs[2], obs[1], obs[0],
                 it.exp[19:4], it.exp[3], it.exp[2], it.exp[1], it.exp[0]);
      end
    end
  end

  task automatic expect_now(string req, logic [19:0] e);
    item_t it;
    it.req = req;
    it.exp = e;
    exp_q.push_back(it);
    -> sample_ev;
    #0.1;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  task automatic aux_pulse();
    tick_aux = 1'b1;
    @(negedge clk);
    tick_aux = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        failures++;
        $display("FAIL watchdog expired actual cycles=%0d expected below 150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    expect_now("R11 reset state", mk(16'h6931, 0, 0, 0, 0));

    wr(16'h5A09);
    expect_now("R1 R3 R4 keyed write stored, clear bit not kept", mk(16'h6901, 0, 0, 0, 0));
    wait_n(63);
    expect_now("R5 no expiry after 63 ticks", mk(16'h6901, 0, 0, 0, 0));
    wait_n(1);
    expect_now("R5 expiry pulse after 64 ticks", mk(16'h6901, 1, 1, 0, 0));
    wait_n(1);
    expect_now("R5 pulse lasts one cycle", mk(16'h6901, 0, 1, 0, 0));

    wait_n(30);
    wr(16'h5A09);
    expect_now("R4 restart write", mk(16'h6901, 0, 1, 0, 0));
    wait_n(63);
    expect_now("R4 no expiry 63 ticks after restart", mk(16'h6901, 0, 1, 0, 0));
    wait_n(1);
    expect_now("R4 expiry 64 ticks after restart", mk(16'h6901, 1, 1, 0, 0));
    wait_n(1);

    wr(16'h1234);
    expect_now("R2 wrong key reset request", mk(16'h6901, 1, 0, 1, 0));
    wait_n(1);
    expect_now("R2 pulse one cycle, settings kept", mk(16'h6901, 0, 0, 1, 0));
    wr(16'h5B3F);
    expect_now("R2 near-miss key rejected", mk(16'h6901, 1, 0, 1, 0));
    wait_n(1);

    wr(16'h5A19);
    expect_now("R6 interval select 01 stored", mk(16'h6911, 0, 0, 1, 0));
    wait_n(511);
    expect_now("R6 no expiry after 511 ticks", mk(16'h6911, 0, 0, 1, 0));
    wait_n(1);
    expect_now("R6 expiry after 512 ticks", mk(16'h6911, 1, 1, 0, 0));
    wait_n(1);

    wr(16'h5A08);
    expect_now("R7 stop written", mk(16'h6900, 0, 1, 0, 0));
    wait_n(200);
    expect_now("R7 no expiry while stopped", mk(16'h6900, 0, 1, 0, 0));

    wr(16'h5A0D);
    expect_now("R9 interval mode set", mk(16'h6905, 0, 1, 0, 0));
    wait_n(63);
    expect_now("R9 no flag after 63 ticks", mk(16'h6905, 0, 1, 0, 0));
    wait_n(1);
    expect_now("R9 flag after 64 ticks, no reset", mk(16'h6905, 0, 1, 0, 1));
    wait_n(100);
    expect_now("R9 flag sticky, still no reset", mk(16'h6905, 0, 1, 0, 1));
    wr(16'h5A0D);
    expect_now("R4 R9 restart clears flag", mk(16'h6905, 0, 1, 0, 0));
    wait_n(63);
    expect_now("R9 count wrapped, no flag at 63", mk(16'h6905, 0, 1, 0, 0));
    wait_n(1);
    expect_now("R9 flag again at 64", mk(16'h6905, 0, 1, 0, 1));

    wr(16'h5A0B);
    expect_now("R8 aux source selected", mk(16'h6903, 0, 1, 0, 0));
    wait_n(200);
    expect_now("R8 no count without aux ticks", mk(16'h6903, 0, 1, 0, 0));
    for (int i = 0; i < 63; i++) aux_pulse();
    expect_now("R8 no expiry after 63 aux ticks", mk(16'h6903, 0, 1, 0, 0));
    tick_aux = 1'b1;
    @(negedge clk);
    tick_aux = 1'b0;
    expect_now("R8 expiry on 64th aux tick", mk(16'h6903, 1, 1, 0, 0));
    wait_n(1);

    wr(16'h5A49);
    expect_now("R10 lock written", mk(16'h6941, 0, 1, 0, 0));
    wait_n(1);
    wr(16'h5A08);
    expect_now("R10 locked restart accepted, settings frozen", mk(16'h6941, 0, 1, 0, 0));
    wait_n(1);
    wr(16'h5A01);
    expect_now("R10 locked write without restart is violation", mk(16'h6941, 1, 0, 1, 0));
    wait_n(1);
    expect_now("R10 settings unchanged after violation", mk(16'h6941, 0, 0, 1, 0));

    do_reset();
    expect_now("R11 reset clears lock and flags", mk(16'h6931, 0, 0, 0, 0));
    wr(16'h5A01);
    expect_now("R1 write accepted after reset", mk(16'h6901, 0, 0, 0, 0));

    wait_n(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule